// File: doc/BRIEF.md
# Bang-Bang Early/Late Phase Detector

This block compares a serial data line against a locally recovered clock and reports, once per clock period, whether the clock edge sits ahead of the data transitions, behind them, centred on them, or whether there was no transition to judge by. It is the decision front end of a binary clock-recovery loop. The loop's pump, filter, oscillator and delay trimming sit elsewhere and consume the four one-hot indications this block produces.

The line is sampled on every rising edge and on every falling edge. Four flip-flops retime three successive samples into one aligned trio. Two exclusive-OR terms over neighbouring samples then classify the trio, and the result is registered. The first sample of the trio is also presented as the retimed data bit.

The serial input is a continuous line sampled by the clock, so there is no valid/ready handshake and no back-pressure. Every output is a plain registered level.

Top module: `bangbang_phase_det`

## Requirements
- R1: The trio is built from three consecutive edges in the order rising, falling, rising. S1 is the line at one rising edge, S2 is the line at the falling edge that follows it, and S3 is the line at the next rising edge.
- R2: All three trio samples change together, only at a rising edge, and then hold for a full clock period. The S1 held in a period equals the S3 held in the period before.
- R3: A trio with S1 equal to S2 and S3 different (patterns 001 and 110, written S1 S2 S3) raises `early` only.
- R4: A trio with S2 equal to S3 and S1 different (patterns 011 and 100) raises `late` only.
- R5: The alternating trios 010 and 101 raise `lock_ind` only.
- R6: The uniform trios 000 and 111 raise `no_trans` only, with neither `early` nor `late`.
- R7: Outside reset, and from the second rising edge after reset is released, exactly one of `early`, `late`, `lock_ind` and `no_trans` is high in every cycle.
- R8: `retimed_data` carries S1 of the trio that the current indication describes.
- R9: For a trio whose S3 is taken at rising edge k, the decision and its `retimed_data` are presented after rising edge k+1 and hold for one period.
- R10: While `rst_n` is low at a clock edge, every flop is cleared synchronously, so all five outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock; both edges sample the line |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | 1 | Serial data line |
| early | output | 1 | Clock leads the data |
| late | output | 1 | Clock lags the data |
| lock_ind | output | 1 | Edge centred on the transition (010 or 101) |
| no_trans | output | 1 | No transition in the trio (000 or 111) |
| retimed_data | output | 1 | Retimed data bit, equal to S1 |

## Verification
Every cycle, the assertions check that the four indications stay one-hot, that each trio class yields its own indication one edge later, that the retimed bit follows S1, that S1 repeats the previous S3, and that reset clears the outputs. Only the bench scenarios can show that the falling-edge sample really comes from the falling edge. They do this by moving the line between the rising and falling edges, so that the sample taken at each edge is seen at the outputs. The scenarios also show the exact latency from the line to the outputs, and that a reset in mid-stream discards stale samples.

// File: rtl/bbpd_pkg.sv
package bbpd_pkg;

  // Classification of one aligned sample trio
  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_EARLY = 2'd1,
    DEC_LATE  = 2'd2,
    DEC_LOCK  = 2'd3
  } bbpd_dec_e;

  // Three samples valid over the same clock period
  typedef struct packed {
    logic first;  // rising edge n
    logic mid;    // falling edge between n and n+1
    logic last;   // rising edge n+1
  } bbpd_trio_t;

endpackage

// File: rtl/bbpd_sampler.sv
module bbpd_sampler
  import bbpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  output bbpd_trio_t trio
);

  logic rise_cap;   // line at latest rising edge
  logic rise_dly;   // line at the rising edge before that
  logic fall_cap;   // line at latest falling edge
  logic fall_dly;   // falling sample moved onto the rising edge

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_cap <= 1'b0;
      rise_dly <= 1'b0;
      fall_dly <= 1'b0;
    end else begin
      rise_cap <= din;
      rise_dly <= rise_cap;
      fall_dly <= fall_cap;
    end
  end

  always_ff @(negedge clk) begin
    if (!rst_n) fall_cap <= 1'b0;
    else        fall_cap <= din;
  end

  assign trio.first = rise_dly;
  assign trio.mid   = fall_dly;
  assign trio.last  = rise_cap;

  // R2: the oldest sample of this period is the newest of the last period
  p_first_follows_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (trio.first == $past(trio.last)));

endmodule

// File: rtl/bbpd_decide.sv
module bbpd_decide
  import bbpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bbpd_trio_t trio,
  output logic       early,
  output logic       late,
  output logic       lock_ind,
  output logic       no_trans,
  output logic       retimed_data
);

  logic      edge_ab;  // transition between first and mid sample
  logic      edge_bc;  // transition between mid and last sample
  bbpd_dec_e dec;

  always_comb begin
    edge_ab = trio.first ^ trio.mid;
    edge_bc = trio.mid ^ trio.last;
    unique case ({edge_ab, edge_bc})
      2'b01:   dec = DEC_EARLY;
      2'b10:   dec = DEC_LATE;
      2'b11:   dec = DEC_LOCK;
      default: dec = DEC_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      early        <= 1'b0;
      late         <= 1'b0;
      lock_ind     <= 1'b0;
      no_trans     <= 1'b0;
      retimed_data <= 1'b0;
    end else begin
      early        <= (dec == DEC_EARLY);
      late         <= (dec == DEC_LATE);
      lock_ind     <= (dec == DEC_LOCK);
      no_trans     <= (dec == DEC_NONE);
      retimed_data <= trio.first;
    end
  end

  // R3
  p_early_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(trio) == 3'b001 || $past(trio) == 3'b110)) |-> early);
  // R4
  p_late_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(trio) == 3'b011 || $past(trio) == 3'b100)) |-> late);
  // R5
  p_lock_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(trio) == 3'b010 || $past(trio) == 3'b101)) |-> lock_ind);
  // R6
  p_flat_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(trio) == 3'b000 || $past(trio) == 3'b111))
      |-> (no_trans && !early && !late));
  // R7
  p_one_hot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($countones({early, late, lock_ind, no_trans}) == 1));
  // R8
  p_retimed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (retimed_data == $past(trio.first)));
  // R10
  p_reset_clears_r10: assert property (@(posedge clk)
    !rst_n |=> !(early || late || lock_ind || no_trans || retimed_data));

endmodule

// File: rtl/bangbang_phase_det.sv
module bangbang_phase_det
  import bbpd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  output logic early,
  output logic late,
  output logic lock_ind,
  output logic no_trans,
  output logic retimed_data
);

  bbpd_trio_t trio;

  bbpd_sampler u_sampler (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (data_in),
    .trio  (trio)
  );

  bbpd_decide u_decide (
    .clk          (clk),
    .rst_n        (rst_n),
    .trio         (trio),
    .early        (early),
    .late         (late),
    .lock_ind     (lock_ind),
    .no_trans     (no_trans),
    .retimed_data (retimed_data)
  );

endmodule

// File: tb/tb_bangbang_phase_det.sv
module tb_bangbang_phase_det;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_in = 1'b0;
  logic early, late, lock_ind, no_trans, retimed_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int       due;
    logic [3:0] onehot;  // {early, late, lock_ind, no_trans}
    logic     rd;
    logic [2:0] pat;
  } exp_t;
  exp_t sb[$];

  bit have_prev = 0;
  bit prev_r = 0;
  bit prev_f = 0;

  bangbang_phase_det dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_in      (data_in),
    .early        (early),
    .late         (late),
    .lock_ind     (lock_ind),
    .no_trans     (no_trans),
    .retimed_data (retimed_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference decision table, pattern written S1 S2 S3
  function automatic logic [3:0] ref_dec(input logic [2:0] p);
    case (p)
      3'b001, 3'b110: ref_dec = 4'b1000;  // early
      3'b011, 3'b100: ref_dec = 4'b0100;  // late
      3'b010, 3'b101: ref_dec = 4'b0010;  // lock
      default:        ref_dec = 4'b0001;  // no transition
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] oh);
    case (oh)
      4'b1000: req_of = "R3";
      4'b0100: req_of = "R4";
      4'b0010: req_of = "R5";
      default: req_of = "R6";
    endcase
  endfunction

  // One period: value r held across a rising edge, value f held across the next falling edge
  task automatic drive_slot(input bit r, input bit f);
    exp_t e;
    @(negedge clk); #1 data_in = r;
    @(posedge clk); #1 data_in = f;
    if (have_prev) begin
      e.pat    = {prev_r, prev_f, r};
      e.onehot = ref_dec(e.pat);
      e.rd     = prev_r;
      e.due    = cyc + 1;  // R9: one rising edge after the S3 edge
      sb.push_back(e);
    end
    prev_r = r;
    prev_f = f;
    have_prev = 1;
  endtask

  task automatic check_zero(input string tag);
    checks++;
    if ({early, late, lock_ind, no_trans, retimed_data} !== 5'b0) begin
      failures++;
      $display("FAIL %s reset outputs actual=%b expected=00000", tag,
               {early, late, lock_ind, no_trans, retimed_data});
    end
  endtask

  // Monitor: pop and compare when an expected item falls due
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      if (sb[0].due < cyc) begin
        checks++; failures++;
        $display("FAIL R9 missed item actual=cycle%0d expected=cycle%0d", cyc, sb[0].due);
        void'(sb.pop_front());
      end else if (sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        // R1 R2 R9: sample order and alignment are implied by the pattern matching here
        checks++;
        if ({early, late, lock_ind, no_trans} !== e.onehot) begin
          failures++;
          $display("FAIL %s pattern %b actual=%b expected=%b", req_of(e.onehot), e.pat,
                   {early, late, lock_ind, no_trans}, e.onehot);
        end
        checks++;
        if ($countones({early, late, lock_ind, no_trans}) != 1) begin
          failures++;
          $display("FAIL R7 one-hot actual=%b expected=one bit", {early, late, lock_ind, no_trans});
        end
        checks++;
        if (retimed_data !== e.rd) begin
          failures++;
          $display("FAIL R8 retimed_data pattern %b actual=%b expected=%b", e.pat, retimed_data, e.rd);
        end
      end
    end
  end

  task automatic do_reset(input int n);
    sb.delete();
    have_prev = 0;
    @(negedge clk); rst_n = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 data_in = ~data_in;
      @(negedge clk); check_zero("R10");
    end
    @(negedge clk); rst_n = 1;
  endtask

  task automatic print_summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    bit [7:0] lfsr;
    rst_n = 0;
    repeat (3) begin
      @(negedge clk); check_zero("R10");
    end
    rst_n = 1;

    // Exhaustive trios: walk every (r, f, next r) combination, R1 R3 R4 R5 R6
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 2; c++) begin
          drive_slot(a[0], b[0]);
          drive_slot(c[0], c[0]);
        end

    // Transition just before the falling edge each period: clock late, R4
    for (int i = 0; i < 8; i++) drive_slot(i[0], ~i[0]);
    // Transition just after the falling edge: clock early, R3
    for (int i = 0; i < 8; i++) drive_slot(i[1], i[1]);
    // Alternating line at half rate of edges: lock, R5
    for (int i = 0; i < 8; i++) drive_slot(1'b1, 1'b0);
    // Flat line: no transitions, R6
    for (int i = 0; i < 6; i++) drive_slot(1'b1, 1'b1);

    // Mid-stream reset discards stale samples, R10
    do_reset(2);

    // Pseudo-random stream from an 8-bit LFSR
    lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      drive_slot(lfsr[0], lfsr[3]);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R9 pending items actual=%0d expected=0", sb.size());
    end
    done = 1;
    print_summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      print_summary();
      $finish;
    end
  end

endmodule